// File: doc/BRIEF.md
# Integer Decode and Execute Unit for a Thirteen-Instruction Subset

This block is the combinational heart of a small 32-bit integer core. One 32-bit instruction word, the address it was fetched from, and the two values read from the register file go in. The outputs give the core everything it needs for that instruction. They name the source and destination registers and say whether a write-back is needed. They carry a six-bit operation code and the arithmetic result. They drive the read and write strobes for the data memory, with the word to store. They say whether control flow leaves the sequential path, and where it goes.

The unit handles register-register add, subtract, and, or, xor, shift left and logical shift right. It also handles add-immediate, word load, word store, branch-if-equal, signed branch-if-less and jump-and-link. Any other encoding is decoded as a no-operation, so the block never produces side effects for it. Branch and jump targets are resolved here rather than in a later stage. This lets a fetch unit redirect after a single combinational pass.

Top module: `rvsub_exec_unit`

## Requirements
- R1: Opcode 0110011 with funct7 0000000 decodes funct3 000 as add (op code 000001), 111 as and (000101), 110 as or (000110) and 100 as xor (000111). Funct7 0100000 with funct3 000 decodes as subtract (000010). Each of these asserts the write-enable and puts the operation on the two register values in the result.
- R2: Opcode 0110011 with funct7 0000000 decodes funct3 001 as shift left (000011) and funct3 101 as logical shift right (001000). The shift amount is the low five bits of the second register value, and the right shift fills with zeros.
- R3: Opcode 0010011 with funct3 000 is add-immediate. It uses op code 000001 with the sign-extended bits 31:20 as second operand, and asserts the write-enable.
- R4: Opcode 0000011 with funct3 010 is a word load. It asserts the memory read strobe and the write-enable, and gives rs1 plus the sign-extended bits 31:20 as the result (the address).
- R5: Opcode 0100011 with funct3 010 is a word store. It asserts the memory write strobe, gives rs1 plus the sign-extended immediate {bits 31:25, bits 11:7} as the address, and passes the second register value as the store data. The write-enable stays low.
- R6: Opcode 1100011 with funct3 000 (equal) or 100 (signed less-than) is a conditional branch with op code 000010. The result is rs1 minus rs2. The target is PC plus the sign-extended immediate {bit31, bit7, bits 30:25, bits 11:8, 0}. The taken flag follows the comparison, and the write-enable stays low.
- R7: Opcode 1101111 is jump-and-link with op code 000100. It is always taken. The target is PC plus the sign-extended immediate {bit31, bits 19:12, bit20, bits 30:21, 0}. The result is PC+4, and the write-enable is high.
- R8: Any encoding outside R1 to R7 gives op code 000000. All strobes and flags are low, and the result, target, store data and all register indices are zero.
- R9: The rs1 index (bits 19:15), rs2 index (bits 24:20) and rd index (bits 11:7) are passed out only when the instruction reads or writes that register. Otherwise each index is zero.
- R10: Subtraction adds the two's complement of the second operand and wraps modulo 2^32 (0 minus 1 gives FFFFFFFF). Addition wraps the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inInst | input | 32 | instruction word |
| inPc | input | 32 | address of the instruction |
| inRs1Val | input | 32 | first register read value |
| inRs2Val | input | 32 | second register read value |
| outRs1Idx | output | 5 | first source register index |
| outRs2Idx | output | 5 | second source register index |
| outRdIdx | output | 5 | destination register index |
| outRdWrEn | output | 1 | destination write-back request |
| outAluOp | output | 6 | operation code |
| outAluResult | output | 32 | arithmetic result, memory address or link value |
| outMemRd | output | 1 | data memory read strobe |
| outMemWr | output | 1 | data memory write strobe |
| outStoreData | output | 32 | word to store |
| outBranchTaken | output | 1 | control flow redirect |
| outTarget | output | 32 | redirect address |

## Verification
The embedded checks assume that the PC presented with an instruction is word aligned. Under that assumption every target is even, and the taken-flag checks rely on it. They also assume every input is a defined two-state value once the instruction is applied. The bench only ever drives PC values that are multiples of four. It applies each instruction word, PC and register pair together in one step, so no check sees a half-updated input set.

// File: rtl/rvsub_pkg.sv
package rvsub_pkg;

  localparam int InstW = 32;
  localparam int RegIdxW = 5;
  localparam int AluOpW = 6;

  localparam logic [6:0] OpcRegReg = 7'b0110011;
  localparam logic [6:0] OpcRegImm = 7'b0010011;
  localparam logic [6:0] OpcLoad   = 7'b0000011;
  localparam logic [6:0] OpcStore  = 7'b0100011;
  localparam logic [6:0] OpcBranch = 7'b1100011;
  localparam logic [6:0] OpcJump   = 7'b1101111;

  typedef enum logic [AluOpW-1:0] {
    ALU_NONE = 6'b000000,
    ALU_ADD  = 6'b000001,
    ALU_SUB  = 6'b000010,
    ALU_SLL  = 6'b000011,
    ALU_LINK = 6'b000100,
    ALU_AND  = 6'b000101,
    ALU_OR   = 6'b000110,
    ALU_XOR  = 6'b000111,
    ALU_SRL  = 6'b001000
  } aluOpE;

  typedef enum logic [2:0] {
    IMM_NONE,
    IMM_I,
    IMM_S,
    IMM_B,
    IMM_J
  } immSelE;

  typedef struct packed {
    aluOpE  aluOp;
    immSelE immSel;
    logic   useRs1;
    logic   useRs2;
    logic   rdWrEn;
    logic   memRd;
    logic   memWr;
    logic   isBranch;
    logic   brLess;
    logic   isJal;
  } ctrlStrobesT;

  localparam ctrlStrobesT CtrlIdle = '{
    aluOp: ALU_NONE, immSel: IMM_NONE, useRs1: 1'b0, useRs2: 1'b0,
    rdWrEn: 1'b0, memRd: 1'b0, memWr: 1'b0, isBranch: 1'b0,
    brLess: 1'b0, isJal: 1'b0
  };

endpackage

// File: rtl/rvsub_ctrl.sv
module rvsub_ctrl
  import rvsub_pkg::*;
(
  input  logic [6:0]  opcode,
  input  logic [2:0]  funct3,
  input  logic [6:0]  funct7,
  output ctrlStrobesT ctrl
);

  localparam logic [6:0] F7Base = 7'b0000000;
  localparam logic [6:0] F7Alt  = 7'b0100000;

  always_comb begin
    ctrl = CtrlIdle;
    unique case (opcode)
      OpcRegReg: begin
        if (funct7 == F7Base) begin
          unique case (funct3)
            3'b000:  ctrl.aluOp = ALU_ADD;
            3'b111:  ctrl.aluOp = ALU_AND;
            3'b110:  ctrl.aluOp = ALU_OR;
            3'b100:  ctrl.aluOp = ALU_XOR;
            3'b001:  ctrl.aluOp = ALU_SLL;
            3'b101:  ctrl.aluOp = ALU_SRL;
            default: ctrl.aluOp = ALU_NONE;
          endcase
        end else if (funct7 == F7Alt && funct3 == 3'b000) begin
          ctrl.aluOp = ALU_SUB;
        end
        if (ctrl.aluOp != ALU_NONE) begin
          ctrl.useRs1 = 1'b1;
          ctrl.useRs2 = 1'b1;
          ctrl.rdWrEn = 1'b1;
        end
      end
      OpcRegImm: begin
        if (funct3 == 3'b000) begin
          ctrl.aluOp  = ALU_ADD;
          ctrl.immSel = IMM_I;
          ctrl.useRs1 = 1'b1;
          ctrl.rdWrEn = 1'b1;
        end
      end
      OpcLoad: begin
        if (funct3 == 3'b010) begin
          ctrl.aluOp  = ALU_ADD;
          ctrl.immSel = IMM_I;
          ctrl.useRs1 = 1'b1;
          ctrl.rdWrEn = 1'b1;
          ctrl.memRd  = 1'b1;
        end
      end
      OpcStore: begin
        if (funct3 == 3'b010) begin
          ctrl.aluOp  = ALU_ADD;
          ctrl.immSel = IMM_S;
          ctrl.useRs1 = 1'b1;
          ctrl.useRs2 = 1'b1;
          ctrl.memWr  = 1'b1;
        end
      end
      OpcBranch: begin
        if (funct3 == 3'b000 || funct3 == 3'b100) begin
          ctrl.aluOp    = ALU_SUB;
          ctrl.immSel   = IMM_B;
          ctrl.useRs1   = 1'b1;
          ctrl.useRs2   = 1'b1;
          ctrl.isBranch = 1'b1;
          ctrl.brLess   = funct3[2];
        end
      end
      OpcJump: begin
        ctrl.aluOp  = ALU_LINK;
        ctrl.immSel = IMM_J;
        ctrl.rdWrEn = 1'b1;
        ctrl.isJal  = 1'b1;
      end
      default: ctrl = CtrlIdle;
    endcase
  end

  always_comb begin
    assert_strobe_excl_R8: assert (!(ctrl.memRd && ctrl.memWr))
      else $error("load and store strobes both high");
    assert_store_nowrite_R5: assert (!(ctrl.memWr && ctrl.rdWrEn))
      else $error("store requests register write");
  end

endmodule

// File: rtl/rvsub_datapath.sv
module rvsub_datapath
  import rvsub_pkg::*;
#(
  parameter int DataW = 32
) (
  input  ctrlStrobesT       ctrl,
  input  logic [31:7]       instHi,
  input  logic [DataW-1:0]  pc,
  input  logic [DataW-1:0]  rs1Val,
  input  logic [DataW-1:0]  rs2Val,
  output logic [DataW-1:0]  aluResult,
  output logic [DataW-1:0]  storeData,
  output logic              branchTaken,
  output logic [DataW-1:0]  target
);

  localparam int ShamtW = $clog2(DataW);
  localparam logic [DataW-1:0] InstBytes = DataW'(4);

  logic [DataW-1:0] immI, immS, immB, immJ, immSel;
  logic [DataW-1:0] opB, negB, diff;
  logic             isEq, isLess;

  // Immediate formats, each sign-extended from the instruction's top bit
  assign immI = {{(DataW-12){instHi[31]}}, instHi[31:20]};
  assign immS = {{(DataW-12){instHi[31]}}, instHi[31:25], instHi[11:7]};
  assign immB = {{(DataW-13){instHi[31]}}, instHi[31], instHi[7],
                 instHi[30:25], instHi[11:8], 1'b0};
  assign immJ = {{(DataW-21){instHi[31]}}, instHi[31], instHi[19:12],
                 instHi[20], instHi[30:21], 1'b0};

  always_comb begin
    unique case (ctrl.immSel)
      IMM_I:   immSel = immI;
      IMM_S:   immSel = immS;
      IMM_B:   immSel = immB;
      IMM_J:   immSel = immJ;
      default: immSel = '0;
    endcase
  end

  assign opB  = (ctrl.immSel == IMM_I || ctrl.immSel == IMM_S) ? immSel : rs2Val;
  // Subtract as addition of the two's complement
  assign negB = ~opB + DataW'(1);
  assign diff = rs1Val + negB;

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD:  aluResult = rs1Val + opB;
      ALU_SUB:  aluResult = diff;
      ALU_SLL:  aluResult = rs1Val << opB[ShamtW-1:0];
      ALU_SRL:  aluResult = rs1Val >> opB[ShamtW-1:0];
      ALU_AND:  aluResult = rs1Val & opB;
      ALU_OR:   aluResult = rs1Val | opB;
      ALU_XOR:  aluResult = rs1Val ^ opB;
      ALU_LINK: aluResult = pc + InstBytes;
      default:  aluResult = '0;
    endcase
  end

  assign isEq   = (diff == '0);
  assign isLess = $signed(rs1Val) < $signed(rs2Val);

  assign branchTaken = ctrl.isJal ||
                       (ctrl.isBranch && (ctrl.brLess ? isLess : isEq));
  assign target      = (ctrl.isBranch || ctrl.isJal) ? pc + immSel : '0;
  assign storeData   = ctrl.memWr ? rs2Val : '0;

  always_comb begin
    if (pc[1:0] == 2'b00) begin
      assert_target_even_R6: assert (!branchTaken || target[0] == 1'b0)
        else $error("redirect to odd address");
    end
    assert_link_value_R7: assert (!ctrl.isJal || aluResult == pc + InstBytes)
      else $error("link value is not the next instruction");
  end

endmodule

// File: rtl/rvsub_exec_unit.sv
module rvsub_exec_unit
  import rvsub_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic [InstW-1:0]   inInst,
  input  logic [DataW-1:0]   inPc,
  input  logic [DataW-1:0]   inRs1Val,
  input  logic [DataW-1:0]   inRs2Val,
  output logic [RegIdxW-1:0] outRs1Idx,
  output logic [RegIdxW-1:0] outRs2Idx,
  output logic [RegIdxW-1:0] outRdIdx,
  output logic               outRdWrEn,
  output logic [AluOpW-1:0]  outAluOp,
  output logic [DataW-1:0]   outAluResult,
  output logic               outMemRd,
  output logic               outMemWr,
  output logic [DataW-1:0]   outStoreData,
  output logic               outBranchTaken,
  output logic [DataW-1:0]   outTarget
);

  ctrlStrobesT ctrl;

  rvsub_ctrl i_ctrl (
    .opcode (inInst[6:0]),
    .funct3 (inInst[14:12]),
    .funct7 (inInst[31:25]),
    .ctrl   (ctrl)
  );

  rvsub_datapath #(.DataW(DataW)) i_datapath (
    .ctrl        (ctrl),
    .instHi      (inInst[31:7]),
    .pc          (inPc),
    .rs1Val      (inRs1Val),
    .rs2Val      (inRs2Val),
    .aluResult   (outAluResult),
    .storeData   (outStoreData),
    .branchTaken (outBranchTaken),
    .target      (outTarget)
  );

  assign outRs1Idx = ctrl.useRs1 ? inInst[19:15] : '0;
  assign outRs2Idx = ctrl.useRs2 ? inInst[24:20] : '0;
  assign outRdIdx  = ctrl.rdWrEn ? inInst[11:7]  : '0;
  assign outRdWrEn = ctrl.rdWrEn;
  assign outAluOp  = ctrl.aluOp;
  assign outMemRd  = ctrl.memRd;
  assign outMemWr  = ctrl.memWr;

  always_comb begin
    assert_nop_quiet_R8: assert (outAluOp != '0 ||
        !(outRdWrEn || outMemRd || outMemWr || outBranchTaken))
      else $error("no-operation produced a side effect");
    assert_redirect_nowrite_R6: assert (!outBranchTaken || !outRdWrEn
        || outAluOp == 6'b000100)
      else $error("taken branch requests register write");
    assert_idx_gated_R9: assert (outRdWrEn || outRdIdx == '0)
      else $error("rd index leaks without write");
  end

endmodule

// File: tb/test_rvsub_exec_unit.sv
module test_rvsub_exec_unit;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] inInst, inPc, inRs1Val, inRs2Val;
  logic [4:0]  outRs1Idx, outRs2Idx, outRdIdx;
  logic        outRdWrEn, outMemRd, outMemWr, outBranchTaken;
  logic [5:0]  outAluOp;
  logic [31:0] outAluResult, outStoreData, outTarget;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  rvsub_exec_unit i_rvsub_exec_unit (
    .inInst(inInst), .inPc(inPc), .inRs1Val(inRs1Val), .inRs2Val(inRs2Val),
    .outRs1Idx(outRs1Idx), .outRs2Idx(outRs2Idx), .outRdIdx(outRdIdx),
    .outRdWrEn(outRdWrEn), .outAluOp(outAluOp), .outAluResult(outAluResult),
    .outMemRd(outMemRd), .outMemWr(outMemWr), .outStoreData(outStoreData),
    .outBranchTaken(outBranchTaken), .outTarget(outTarget)
  );

  function automatic logic [31:0] encR(logic [6:0] f7, logic [4:0] rs2,
      logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] encI(logic [11:0] imm, logic [4:0] rs1,
      logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] encS(logic [11:0] imm, logic [4:0] rs2,
      logic [4:0] rs1, logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] encB(logic [12:0] imm, logic [4:0] rs2,
      logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] encJ(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] inst, logic [31:0] pc,
                       logic [31:0] a, logic [31:0] b);
    @(posedge clk);
    inInst <= inst; inPc <= pc; inRs1Val <= a; inRs2Val <= b;
    @(negedge clk);
  endtask

  task automatic expectNop(string tag);
    chk("R8", {tag, " op"}, 32'(outAluOp), 32'h0);
    chk("R8", {tag, " strobes"},
        32'({outRdWrEn, outMemRd, outMemWr, outBranchTaken}), 32'h0);
    chk("R8", {tag, " result"}, outAluResult, 32'h0);
    chk("R8", {tag, " target"}, outTarget, 32'h0);
    chk("R8", {tag, " store"}, outStoreData, 32'h0);
    chk("R9", {tag, " indices"}, 32'({outRs1Idx, outRs2Idx, outRdIdx}), 32'h0);
  endtask

  task automatic regOp(string req, string nm, logic [6:0] f7, logic [2:0] f3,
      logic [31:0] a, logic [31:0] b, logic [5:0] op, logic [31:0] res);
    apply(encR(f7, 5'd9, 5'd4, f3, 5'd12), 32'h40, a, b);
    chk(req, {nm, " op"}, 32'(outAluOp), 32'(op));
    chk(req, {nm, " result"}, outAluResult, res);
    chk(req, {nm, " wr"}, 32'({outRdWrEn, outMemRd, outMemWr, outBranchTaken}), 32'h8);
    chk("R9", {nm, " idx"}, 32'({outRs1Idx, outRs2Idx, outRdIdx}),
        32'({5'd4, 5'd9, 5'd12}));
  endtask

  task automatic testIdle();
    apply(32'h0, 32'h0, 32'h0, 32'h0);
    expectNop("all-zero word");
  endtask

  task automatic testRegReg();
    regOp("R1", "add", 7'h00, 3'b000, 32'd7, 32'd10, 6'b000001, 32'd17);
    regOp("R1", "sub", 7'h20, 3'b000, 32'd3, 32'd10, 6'b000010, 32'hFFFFFFF9);
    regOp("R1", "and", 7'h00, 3'b111, 32'hF0F0_1234, 32'h0FF0_FF00, 6'b000101, 32'h00F0_1200);
    regOp("R1", "or",  7'h00, 3'b110, 32'hF000_0001, 32'h0000_0F00, 6'b000110, 32'hF000_0F01);
    regOp("R1", "xor", 7'h00, 3'b100, 32'hFFFF_0000, 32'h0F0F_0F0F, 6'b000111, 32'hF0F0_0F0F);
  endtask

  task automatic testWrap();
    regOp("R10", "sub wrap", 7'h20, 3'b000, 32'd0, 32'd1, 6'b000010, 32'hFFFFFFFF);
    regOp("R10", "add wrap", 7'h00, 3'b000, 32'h7FFFFFFF, 32'd1, 6'b000001, 32'h80000000);
    regOp("R10", "sub equal", 7'h20, 3'b000, 32'h1234, 32'h1234, 6'b000010, 32'h0);
  endtask

  task automatic testShifts();
    regOp("R2", "sll low5", 7'h00, 3'b001, 32'h0000_0003, 32'h0000_0021, 6'b000011, 32'h6);
    regOp("R2", "srl zero fill", 7'h00, 3'b101, 32'h8000_0000, 32'd4, 6'b001000, 32'h0800_0000);
    regOp("R2", "srl by 31", 7'h00, 3'b101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'b001000, 32'h1);
  endtask

  task automatic testAddImm();
    apply(encI(12'hFFB, 5'd3, 3'b000, 5'd8, 7'b0010011), 32'h80, 32'd10, 32'hDEAD);
    chk("R3", "addi negative", outAluResult, 32'd5);
    chk("R3", "addi op", 32'(outAluOp), 32'h1);
    chk("R3", "addi wr", 32'({outRdWrEn, outMemRd, outMemWr}), 32'h4);
    chk("R9", "addi idx", 32'({outRs1Idx, outRs2Idx, outRdIdx}), 32'({5'd3, 5'd0, 5'd8}));
    apply(encI(12'h7FF, 5'd3, 3'b000, 5'd8, 7'b0010011), 32'h80, 32'd1, 32'h0);
    chk("R3", "addi max positive", outAluResult, 32'h800);
  endtask

  task automatic testLoad();
    apply(encI(12'hFFC, 5'd2, 3'b010, 5'd6, 7'b0000011), 32'h10, 32'h100, 32'h55);
    chk("R4", "lw addr", outAluResult, 32'hFC);
    chk("R4", "lw strobes", 32'({outRdWrEn, outMemRd, outMemWr, outBranchTaken}), 32'hC);
    chk("R9", "lw idx", 32'({outRs1Idx, outRs2Idx, outRdIdx}), 32'({5'd2, 5'd0, 5'd6}));
  endtask

  task automatic testStore();
    apply(encS(12'hFF8, 5'd11, 5'd2, 3'b010), 32'h10, 32'h200, 32'hCAFE_F00D);
    chk("R5", "sw addr", outAluResult, 32'h1F8);
    chk("R5", "sw data", outStoreData, 32'hCAFE_F00D);
    chk("R5", "sw strobes", 32'({outRdWrEn, outMemRd, outMemWr, outBranchTaken}), 32'h2);
    chk("R9", "sw idx", 32'({outRs1Idx, outRs2Idx, outRdIdx}), 32'({5'd2, 5'd11, 5'd0}));
  endtask

  task automatic testBranches();
    apply(encB(13'h1FF0, 5'd5, 5'd6, 3'b000), 32'h1000, 32'd42, 32'd42);
    chk("R6", "beq equal taken", 32'(outBranchTaken), 32'h1);
    chk("R6", "beq target back", outTarget, 32'h0FF0);
    chk("R6", "beq op", 32'(outAluOp), 32'h2);
    chk("R6", "beq no write", 32'({outRdWrEn, outRdIdx}), 32'h0);
    apply(encB(13'h0010, 5'd5, 5'd6, 3'b000), 32'h1000, 32'd42, 32'd43);
    chk("R6", "beq unequal not taken", 32'(outBranchTaken), 32'h0);
    chk("R6", "beq diff", outAluResult, 32'hFFFFFFFF);
    apply(encB(13'h0800, 5'd5, 5'd6, 3'b100), 32'h2000, 32'hFFFF_FFFF, 32'd1);
    chk("R6", "blt signed taken", 32'(outBranchTaken), 32'h1);
    chk("R6", "blt target fwd", outTarget, 32'h2800);
    apply(encB(13'h0800, 5'd5, 5'd6, 3'b100), 32'h2000, 32'd1, 32'hFFFF_FFFF);
    chk("R6", "blt signed not taken", 32'(outBranchTaken), 32'h0);
    apply(encB(13'h0008, 5'd5, 5'd6, 3'b100), 32'h2000, 32'h8000_0000, 32'h7FFF_FFFF);
    chk("R6", "blt most negative", 32'(outBranchTaken), 32'h1);
    apply(encB(13'h0008, 5'd5, 5'd6, 3'b100), 32'h2000, 32'd7, 32'd7);
    chk("R6", "blt equal not taken", 32'(outBranchTaken), 32'h0);
  endtask

  task automatic testJump();
    apply(encJ(21'h000800, 5'd1), 32'h1000, 32'h0, 32'h0);
    chk("R7", "jal taken", 32'(outBranchTaken), 32'h1);
    chk("R7", "jal target", outTarget, 32'h1800);
    chk("R7", "jal link", outAluResult, 32'h1004);
    chk("R7", "jal op", 32'(outAluOp), 32'h4);
    chk("R9", "jal idx", 32'({outRs1Idx, outRs2Idx, outRdIdx, outRdWrEn}),
        32'({5'd0, 5'd0, 5'd1, 1'b1}));
    apply(encJ(21'h1FF000, 5'd1), 32'h8000, 32'h0, 32'h0);
    chk("R7", "jal negative target", outTarget, 32'h7000);
  endtask

  task automatic testUnsupported();
    apply(encR(7'h20, 5'd1, 5'd2, 3'b111, 5'd3), 32'h0, 32'd5, 32'd6);
    expectNop("and with alt funct7");
    apply(encB(13'h0010, 5'd1, 5'd2, 3'b001), 32'h100, 32'd5, 32'd6);
    expectNop("branch funct3 001");
    apply(32'h1234_50B7, 32'h100, 32'd5, 32'd6);
    expectNop("opcode 0110111");
    apply(encI(12'h003, 5'd2, 3'b001, 5'd3, 7'b0010011), 32'h100, 32'd5, 32'd6);
    expectNop("imm funct3 001");
    apply(encI(12'h004, 5'd2, 3'b000, 5'd3, 7'b0000011), 32'h100, 32'd5, 32'd6);
    expectNop("load funct3 000");
  endtask

  initial begin
    inInst = '0; inPc = '0; inRs1Val = '0; inRs2Val = '0;
    testIdle();
    testRegReg();
    testWrap();
    testShifts();
    testAddImm();
    testLoad();
    testStore();
    testBranches();
    testJump();
    testUnsupported();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule